// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block watches the first twelve bytes of a received Ethernet frame as they stream past and decides whether the frame should be kept. The first six bytes are the destination address. The next six are the source address. The destination is tried against a bank of perfect-match entries, a 64-bit hash table, a broadcast rule and a pass-every-group-address option. The source is tried against its own bank of perfect-match entries. Every entry has its own enable bit and a per-byte mask.

The block takes a byte stream with a qualifier and a frame-start marker, along with static configuration inputs. One cycle after the twelfth header byte is accepted, it raises a decision-valid flag together with a pass/drop verdict and three status bits. These hold until the next frame start. Payload bytes after the header have no effect. The block does no CRC checking of the frame and does not store the frame.

Top module: `rx_addr_filter`

## Requirements
- R1: A byte is accepted on a clock edge where `rx_valid` is high. `rx_sof` high with `rx_valid` marks the first byte (index 0) of a frame. `dec_valid` goes high on the edge that accepts byte index 11, even when idle cycles occur between bytes. It goes low on the edge that accepts the next frame start. In between, `dec_valid`, `dec_pass` and the status bits hold their values.
- R2: Destination entry e matches when each destination byte k (k = 0..5, byte 0 received first) equals `da_addr_tbl[48*e + 8*k +: 8]`. A set bit `da_mask_tbl[6*e + k]` leaves byte k out of the comparison. `st_da_match` is the OR over all entries, and a match passes the frame.
- R3: An entry whose bit in `da_ent_en` or `sa_ent_en` is low never matches, even if its address is equal.
- R4: Source entry e is compared against header bytes 6..11, using `sa_addr_tbl` and `sa_mask_tbl` with the same layout as R2. `st_sa_match` reports whether any enabled source entry matches.
- R5: While `sa_filt_en` is high and `promisc` is low, a frame passes only if `st_sa_match` is also high. While `sa_filt_en` is low, the source result does not affect `dec_pass`.
- R6: The hash index is bits [31:26] of the bitwise complement of a CRC-32. The CRC is computed over destination bytes 0..5, least significant bit first, with the reflected polynomial 0xEDB88320 and an initial value of all ones. `st_hash_hit` is high when `hash_tbl[index]` is set and the hash is enabled for the frame's type. That means `hash_mc_en` when bit 0 of byte 0 (the group bit) is 1, and `hash_uc_en` otherwise. A hit passes the frame.
- R7: With `pass_all_mc` high, every non-broadcast frame whose group bit is set passes. Unicast frames are unaffected.
- R8: A destination of all ones passes unless `bcast_block` is high. When `bcast_block` is high, such a frame is dropped even if `pass_all_mc` is set or a perfect entry matches.
- R9: With `promisc` high, every frame passes, and `st_da_match`, `st_sa_match` and `st_hash_hit` still report their true values.
- R10: Bytes received before the first frame start, and bytes after index 11, change no output.
- R11: After reset, `dec_valid`, `dec_pass` and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Marks byte 0 of a frame, qualified by rx_valid |
| rx_valid | input | 1 | Byte qualifier |
| rx_byte | input | 8 | Received byte |
| da_addr_tbl | input | 48*N_DA | Destination entry addresses |
| da_mask_tbl | input | 6*N_DA | Destination per-byte masks (1 = ignore byte) |
| da_ent_en | input | N_DA | Destination entry enables |
| sa_addr_tbl | input | 48*N_SA | Source entry addresses |
| sa_mask_tbl | input | 6*N_SA | Source per-byte masks |
| sa_ent_en | input | N_SA | Source entry enables |
| sa_filt_en | input | 1 | Require a source match to pass |
| hash_tbl | input | HASH_W | Hash bit table |
| hash_mc_en | input | 1 | Apply hash to group destinations |
| hash_uc_en | input | 1 | Apply hash to individual destinations |
| pass_all_mc | input | 1 | Pass every group destination |
| promisc | input | 1 | Pass every frame |
| bcast_block | input | 1 | Drop all-ones destinations |
| dec_valid | output | 1 | Decision and status valid |
| dec_pass | output | 1 | Frame accepted |
| st_da_match | output | 1 | Some destination entry matched |
| st_sa_match | output | 1 | Some source entry matched |
| st_hash_hit | output | 1 | Hash table bit hit |

## Verification
The hardest case to reach from the ports is a hash hit on one specific table bit. A hit depends on a CRC of the destination that no port exposes. The bench therefore computes the index from the rule in R6, sets only that one table bit, and then changes the type enables and the group bit to show the hit both appearing and disappearing. A second awkward case is timing. The verdict must not appear before byte index 11, and it must not move afterwards. To reach this, the bench sends eleven bytes with idle gaps, inspects the outputs, then sends the last byte and a trailing stream of payload bytes.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   localparam int MAC_BYTES = 6;
   localparam int HDR_BYTES = 2 * MAC_BYTES;
   localparam int MAC_BITS  = 8 * MAC_BYTES;
   localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

   // One byte of reflected CRC-32, least significant bit first
   function automatic logic [31:0] crc32_byte(input logic [31:0] c_in, input logic [7:0] b);
      logic [31:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REFL;
         else             c = c >> 1;
      end
      return c;
   endfunction
endpackage

// File: rtl/addr_cmp_bank.sv
module addr_cmp_bank
   import rxaf_pkg::*;
#(
   parameter int N_ENT    = 4,
   parameter int BASE_IDX = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      take,
   input  logic [3:0]                byte_idx,
   input  logic [7:0]                byte_in,
   input  logic [N_ENT*MAC_BITS-1:0] addr_tbl,
   input  logic [N_ENT*MAC_BYTES-1:0] mask_tbl,
   input  logic [N_ENT-1:0]          ent_en,
   output logic [N_ENT-1:0]          hit_nx
);
   localparam logic [3:0] LO_IDX = 4'(BASE_IDX);
   localparam logic [3:0] HI_IDX = 4'(BASE_IDX + MAC_BYTES);

   logic       in_range;
   logic [3:0] rel;

   assign in_range = (byte_idx >= LO_IDX) && (byte_idx < HI_IDX);
   assign rel      = byte_idx - LO_IDX;

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic ok_q;
      logic base;
      logic byte_ok;

      assign base    = start ? ent_en[e] : ok_q;
      assign byte_ok = mask_tbl[e*MAC_BYTES + int'(rel[2:0])] ||
                       (addr_tbl[e*MAC_BITS + 8*int'(rel[2:0]) +: 8] == byte_in);
      assign hit_nx[e] = (take && in_range) ? (base && byte_ok) : base;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ok_q <= 1'b0;
         else if (take) ok_q <= hit_nx[e];
      end
   end
endmodule

// File: rtl/hash_crc_unit.sv
module hash_crc_unit
   import rxaf_pkg::*;
#(
   parameter int HASH_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              take,
   input  logic [3:0]        byte_idx,
   input  logic [7:0]        byte_in,
   input  logic [HASH_W-1:0] hash_tbl,
   output logic              tbl_bit
);
   localparam int IDX_W = $clog2(HASH_W);

   logic [31:0]      crc_q;
   logic [31:0]      crc_in;
   logic [31:0]      crc_fin;
   logic [IDX_W-1:0] idx;

   assign crc_in  = start ? 32'hFFFF_FFFF : crc_q;
   assign crc_fin = ~crc_q;
   assign idx     = crc_fin[31 -: IDX_W];
   assign tbl_bit = hash_tbl[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= 32'hFFFF_FFFF;
      else if (take && (byte_idx < 4'(MAC_BYTES)))
         crc_q <= crc32_byte(crc_in, byte_in);
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxaf_pkg::*;
#(
   parameter int N_DA    = 4,
   parameter int N_SA    = 3,
   parameter int HASH_W  = 64,
   parameter bit HASH_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rx_sof,
   input  logic                       rx_valid,
   input  logic [7:0]                 rx_byte,
   input  logic [N_DA*MAC_BITS-1:0]   da_addr_tbl,
   input  logic [N_DA*MAC_BYTES-1:0]  da_mask_tbl,
   input  logic [N_DA-1:0]            da_ent_en,
   input  logic [N_SA*MAC_BITS-1:0]   sa_addr_tbl,
   input  logic [N_SA*MAC_BYTES-1:0]  sa_mask_tbl,
   input  logic [N_SA-1:0]            sa_ent_en,
   input  logic                       sa_filt_en,
   input  logic [HASH_W-1:0]          hash_tbl,
   input  logic                       hash_mc_en,
   input  logic                       hash_uc_en,
   input  logic                       pass_all_mc,
   input  logic                       promisc,
   input  logic                       bcast_block,
   output logic                       dec_valid,
   output logic                       dec_pass,
   output logic                       st_da_match,
   output logic                       st_sa_match,
   output logic                       st_hash_hit
);
   localparam int         CNT_W    = $clog2(HDR_BYTES + 1);
   localparam logic [3:0] LAST_IDX = 4'(HDR_BYTES - 1);

   // Elaboration-time parameter checks
   if (N_DA < 1 || N_DA > 8) begin : g_bad_da
      $error("rx_addr_filter: N_DA must lie in 1..8");
   end
   if (N_SA < 1 || N_SA > 8) begin : g_bad_sa
      $error("rx_addr_filter: N_SA must lie in 1..8");
   end
   if (HASH_W < 2 || HASH_W > 256 || (HASH_W & (HASH_W - 1)) != 0) begin : g_bad_hash
      $error("rx_addr_filter: HASH_W must be a power of two in 2..256");
   end
   if (CNT_W != 4) begin : g_bad_cnt
      $error("rx_addr_filter: header counter width mismatch");
   end

   // Byte position tracking
   logic [3:0] cnt_q;
   logic       in_frame_q;
   logic       start;
   logic       take;
   logic [3:0] cur_idx;

   assign start   = rx_valid && rx_sof;
   assign take    = rx_valid && (rx_sof || (in_frame_q && (cnt_q < 4'(HDR_BYTES))));
   assign cur_idx = rx_sof ? 4'd0 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         in_frame_q <= 1'b0;
      end else if (take) begin
         cnt_q      <= 4'(cur_idx + 4'd1);
         in_frame_q <= 1'b1;
      end
   end

   // Perfect-match banks
   logic [N_DA-1:0] da_hit_nx;
   logic [N_SA-1:0] sa_hit_nx;

   addr_cmp_bank #(.N_ENT(N_DA), .BASE_IDX(0)) u_da_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .take     (take),
      .byte_idx (cur_idx),
      .byte_in  (rx_byte),
      .addr_tbl (da_addr_tbl),
      .mask_tbl (da_mask_tbl),
      .ent_en   (da_ent_en),
      .hit_nx   (da_hit_nx)
   );

   addr_cmp_bank #(.N_ENT(N_SA), .BASE_IDX(MAC_BYTES)) u_sa_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .take     (take),
      .byte_idx (cur_idx),
      .byte_in  (rx_byte),
      .addr_tbl (sa_addr_tbl),
      .mask_tbl (sa_mask_tbl),
      .ent_en   (sa_ent_en),
      .hit_nx   (sa_hit_nx)
   );

   // Hash lookup, present only when enabled
   logic tbl_bit;
   if (HASH_EN) begin : g_hash
      hash_crc_unit #(.HASH_W(HASH_W)) u_hash (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (start),
         .take     (take),
         .byte_idx (cur_idx),
         .byte_in  (rx_byte),
         .hash_tbl (hash_tbl),
         .tbl_bit  (tbl_bit)
      );
   end else begin : g_no_hash
      logic unused_hash;
      assign unused_hash = ^hash_tbl;
      assign tbl_bit     = 1'b0;
   end

   // Group and broadcast flags from the destination
   logic mc_q;
   logic bc_q;
   logic bc_base;
   logic bc_nx;

   assign bc_base = start ? 1'b1 : bc_q;
   assign bc_nx   = (take && (cur_idx < 4'(MAC_BYTES))) ? (bc_base && (rx_byte == 8'hFF)) : bc_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mc_q <= 1'b0;
         bc_q <= 1'b0;
      end else begin
         if (start) mc_q <= rx_byte[0];
         if (take)  bc_q <= bc_nx;
      end
   end

   // Verdict at the last header byte
   logic da_any;
   logic sa_any;
   logic hash_use;
   logic hash_hit;
   logic da_ok;
   logic pass_nx;
   logic final_byte;

   assign da_any     = |da_hit_nx;
   assign sa_any     = |sa_hit_nx;
   assign hash_use   = mc_q ? hash_mc_en : hash_uc_en;
   assign hash_hit   = hash_use && tbl_bit;
   assign da_ok      = bc_nx ? !bcast_block : (da_any || hash_hit || (mc_q && pass_all_mc));
   assign pass_nx    = promisc || (da_ok && (!sa_filt_en || sa_any));
   assign final_byte = take && !start && (cur_idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid   <= 1'b0;
         dec_pass    <= 1'b0;
         st_da_match <= 1'b0;
         st_sa_match <= 1'b0;
         st_hash_hit <= 1'b0;
      end else if (start) begin
         dec_valid   <= 1'b0;
         dec_pass    <= 1'b0;
         st_da_match <= 1'b0;
         st_sa_match <= 1'b0;
         st_hash_hit <= 1'b0;
      end else if (final_byte) begin
         dec_valid   <= 1'b1;
         dec_pass    <= pass_nx;
         st_da_match <= da_any;
         st_sa_match <= sa_any;
         st_hash_hit <= hash_hit;
      end
   end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_sof,
   input logic rx_valid,
   input logic promisc,
   input logic sa_filt_en,
   input logic hash_mc_en,
   input logic hash_uc_en,
   input logic dec_valid,
   input logic dec_pass,
   input logic st_da_match,
   input logic st_sa_match,
   input logic st_hash_hit
);
   logic [3:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          seen_q <= '0;
      else if (rx_valid && rx_sof)                         seen_q <= 4'd1;
      else if (rx_valid && seen_q != 4'd0 && seen_q < 4'd12) seen_q <= seen_q + 4'd1;
   end

   // R1: verdict appears only once twelve header bytes have been accepted
   a_r1_after_twelve: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> seen_q == 4'd12);

   // R1: a frame start withdraws the verdict
   a_r1_clear_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_sof) |=> !dec_valid);

   // R1, R10: verdict and status hold until the next frame start
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !(rx_valid && rx_sof)) |=>
         (dec_valid && $stable(dec_pass) && $stable(st_da_match) &&
          $stable(st_sa_match) && $stable(st_hash_hit)));

   // R9: promiscuous mode always passes
   a_r9_promisc_pass: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dec_valid) && $past(promisc)) |-> dec_pass);

   // R5: source filtering demands a source match
   a_r5_sa_required: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dec_valid) && $past(sa_filt_en) && !$past(promisc) && !st_sa_match) |-> !dec_pass);

   // R6: a hash hit needs one of the hash enables
   a_r6_hash_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dec_valid) && st_hash_hit) |-> $past(hash_mc_en || hash_uc_en));
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (.*);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
   localparam int N_DA = 4;
   localparam int N_SA = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               rx_sof = 1'b0;
   logic               rx_valid = 1'b0;
   logic [7:0]         rx_byte = '0;
   logic [N_DA*48-1:0] da_addr_tbl = '0;
   logic [N_DA*6-1:0]  da_mask_tbl = '0;
   logic [N_DA-1:0]    da_ent_en = '0;
   logic [N_SA*48-1:0] sa_addr_tbl = '0;
   logic [N_SA*6-1:0]  sa_mask_tbl = '0;
   logic [N_SA-1:0]    sa_ent_en = '0;
   logic               sa_filt_en = 1'b0;
   logic [63:0]        hash_tbl = '0;
   logic               hash_mc_en = 1'b0;
   logic               hash_uc_en = 1'b0;
   logic               pass_all_mc = 1'b0;
   logic               promisc = 1'b0;
   logic               bcast_block = 1'b0;
   logic               dec_valid, dec_pass, st_da_match, st_sa_match, st_hash_hit;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   rx_addr_filter u_dut (.*);

   // Byte k of an address sits at bits [8k+7:8k]; byte 0 is sent first
   localparam logic [47:0] UC_A  = 48'h66_55_44_33_22_10;
   localparam logic [47:0] UC_B  = 48'h0C_0B_0A_09_08_02;
   localparam logic [47:0] MC_A  = 48'hAB_00_00_5E_00_01;
   localparam logic [47:0] SA_X  = 48'hF5_E4_D3_C2_B1_A0;
   localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic chk_dec(input string tag, input logic p, input logic d, input logic s, input logic h);
      chk({tag, " valid"}, dec_valid, 1'b1);
      chk({tag, " pass"},  dec_pass, p);
      chk({tag, " da"},    st_da_match, d);
      chk({tag, " sa"},    st_sa_match, s);
      chk({tag, " hash"},  st_hash_hit, h);
   endtask

   // Send header bytes lo..hi of {sa,da}; a sof is given on byte 0
   task automatic send_range(input logic [47:0] da, input logic [47:0] sa,
                             input int lo, input int hi, input bit gaps);
      logic [95:0] hdr;
      hdr = {sa, da};
      for (int i = lo; i <= hi; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof   = (i == 0);
         rx_byte  = hdr[8*i +: 8];
         if (gaps && (i % 4 == 2)) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_sof   = 1'b0;
         end
      end
      @(negedge clk);
      rx_valid = 1'b0;
      rx_sof   = 1'b0;
   endtask

   task automatic send_frame(input logic [47:0] da, input logic [47:0] sa);
      send_range(da, sa, 0, 11, 1'b0);
   endtask

   task automatic clear_cfg();
      da_addr_tbl = '0; da_mask_tbl = '0; da_ent_en = '0;
      sa_addr_tbl = '0; sa_mask_tbl = '0; sa_ent_en = '0;
      sa_filt_en = 0; hash_tbl = '0; hash_mc_en = 0; hash_uc_en = 0;
      pass_all_mc = 0; promisc = 0; bcast_block = 0;
   endtask

   function automatic int hash_index(input logic [47:0] da);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < 48; k++) begin
         if (c[0] ^ da[k]) c = (c >> 1) ^ 32'hEDB8_8320;
         else              c = c >> 1;
      end
      c = ~c;
      return int'(c[31:26]);
   endfunction

   task automatic t_reset();
      chk("R11 reset valid", dec_valid, 1'b0);
      chk("R11 reset pass",  dec_pass, 1'b0);
      chk("R11 reset da",    st_da_match, 1'b0);
   endtask

   task automatic t_stray();
      // R10: bytes with no frame start are ignored
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'(i);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      chk("R10 stray bytes valid", dec_valid, 1'b0);
   endtask

   task automatic t_da_exact();
      clear_cfg();
      da_addr_tbl[2*48 +: 48] = UC_A;
      da_ent_en = 4'b0100;
      send_frame(UC_A, SA_X);
      chk_dec("R2 exact", 1, 1, 0, 0);
      send_frame(UC_B, SA_X);
      chk_dec("R2 other unicast", 0, 0, 0, 0);
   endtask

   task automatic t_da_mask();
      clear_cfg();
      da_addr_tbl[0 +: 48] = UC_A ^ 48'h00_00_77_00_00_00; // byte 3 differs
      da_ent_en = 4'b0001;
      send_frame(UC_A, SA_X);
      chk_dec("R2 unmasked differ", 0, 0, 0, 0);
      da_mask_tbl[3] = 1'b1;
      send_frame(UC_A, SA_X);
      chk_dec("R2 masked byte3", 1, 1, 0, 0);
   endtask

   task automatic t_disabled();
      clear_cfg();
      da_addr_tbl[48 +: 48] = UC_A;
      sa_addr_tbl[0 +: 48]  = SA_X;
      send_frame(UC_A, SA_X);
      chk_dec("R3 disabled entries", 0, 0, 0, 0);
   endtask

   task automatic t_sa();
      clear_cfg();
      da_addr_tbl[0 +: 48] = UC_A; da_ent_en = 4'b0001;
      sa_addr_tbl[48 +: 48] = SA_X; sa_ent_en = 3'b010;
      send_frame(UC_A, SA_X);
      chk_dec("R4 sa match status", 1, 1, 1, 0);
      sa_filt_en = 1;
      send_frame(UC_A, SA_X);
      chk_dec("R5 sa required and met", 1, 1, 1, 0);
      send_frame(UC_A, SA_X ^ 48'h01_00_00_00_00_00);
      chk_dec("R5 sa required not met", 0, 1, 0, 0);
      sa_mask_tbl[6 + 5] = 1'b1;
      send_frame(UC_A, SA_X ^ 48'h01_00_00_00_00_00);
      chk_dec("R4 sa masked byte5", 1, 1, 1, 0);
      sa_filt_en = 0; sa_mask_tbl = '0;
      send_frame(UC_A, SA_X ^ 48'h01_00_00_00_00_00);
      chk_dec("R5 sa ignored when off", 1, 1, 0, 0);
   endtask

   task automatic t_hash();
      int iu, im;
      clear_cfg();
      iu = hash_index(UC_B);
      im = hash_index(MC_A);
      hash_tbl[iu] = 1'b1;
      hash_uc_en = 1;
      send_frame(UC_B, SA_X);
      chk_dec("R6 unicast hash hit", 1, 0, 0, 1);
      hash_uc_en = 0; hash_mc_en = 1;
      send_frame(UC_B, SA_X);
      chk_dec("R6 unicast hash off", 0, 0, 0, 0);
      hash_tbl = '0; hash_tbl[im] = 1'b1;
      send_frame(MC_A, SA_X);
      chk_dec("R6 multicast hash hit", 1, 0, 0, 1);
      hash_tbl = '0; hash_tbl[(im + 1) % 64] = 1'b1;
      send_frame(MC_A, SA_X);
      chk_dec("R6 multicast bit clear", 0, 0, 0, 0);
   endtask

   task automatic t_allmc();
      clear_cfg();
      pass_all_mc = 1;
      send_frame(MC_A, SA_X);
      chk_dec("R7 pass all group", 1, 0, 0, 0);
      send_frame(UC_B, SA_X);
      chk_dec("R7 unicast unaffected", 0, 0, 0, 0);
   endtask

   task automatic t_bcast();
      clear_cfg();
      send_frame(BCAST, SA_X);
      chk_dec("R8 broadcast passes", 1, 0, 0, 0);
      bcast_block = 1; pass_all_mc = 1;
      da_addr_tbl[0 +: 48] = BCAST; da_ent_en = 4'b0001;
      send_frame(BCAST, SA_X);
      chk_dec("R8 broadcast blocked", 0, 1, 0, 0);
   endtask

   task automatic t_promisc();
      clear_cfg();
      promisc = 1;
      send_frame(UC_B, SA_X);
      chk_dec("R9 promisc no match", 1, 0, 0, 0);
      da_addr_tbl[3*48 +: 48] = UC_B; da_ent_en = 4'b1000;
      sa_addr_tbl[2*48 +: 48] = SA_X; sa_ent_en = 3'b100;
      send_frame(UC_B, SA_X);
      chk_dec("R9 promisc status kept", 1, 1, 1, 0);
   endtask

   task automatic t_timing();
      clear_cfg();
      da_addr_tbl[0 +: 48] = UC_A; da_ent_en = 4'b0001;
      send_range(UC_A, SA_X, 0, 10, 1'b1);
      chk("R1 not valid after 11 bytes", dec_valid, 1'b0);
      send_range(UC_A, SA_X, 11, 11, 1'b0);
      chk_dec("R1 valid after byte 11", 1, 1, 0, 0);
      // R10: payload bytes after the header
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF;
      end
      @(negedge clk);
      rx_valid = 1'b0;
      chk_dec("R10 tail bytes ignored", 1, 1, 0, 0);
      // R1: next frame start withdraws the verdict
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = UC_B[7:0];
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0;
      chk("R1 cleared on sof", dec_valid, 1'b0);
      chk("R1 pass cleared on sof", dec_pass, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stray();
      t_da_exact();
      t_da_mask();
      t_disabled();
      t_sa();
      t_hash();
      t_allmc();
      t_bcast();
      t_promisc();
      t_timing();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule